// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block drives the address side of a multi-register load or store. A start pulse captures a 16-bit register bitmap, a base address, a two-bit stepping mode and a writeback enable. Each cycle that the stall input is low, the block then emits one transfer. A transfer is a register index and a word address, marked by a valid strobe. Registers are visited from the lowest selected index to the highest, and each one takes the next word address.

The lowest selected register always lands at the lowest address. The mode only chooses where the contiguous window sits relative to the base, and in which direction the base moves. After the last transfer the block pulses done. If writeback was requested, it also presents the updated base for the register file to store. The block performs neither the memory transfers nor the register file accesses.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, busy_o, xfer_valid_o, done_o and wb_valid_o are low.
- R2: Each selected register is emitted exactly once, in ascending index order. No unselected register is emitted, and transfers are back to back while stall_i is low.
- R3: Consecutive transfers of one operation have addresses that differ by +4.
- R4: With n selected registers, the first transfer address depends on mode_i as follows: 2'b00 (step up, after) gives base; 2'b01 (step up, before) gives base+4; 2'b10 (step down, after) gives base-4n+4; 2'b11 (step down, before) gives base-4n. All arithmetic is modulo 2^32.
- R5: The writeback value is base+4n for modes 2'b00 and 2'b01, and base-4n for modes 2'b10 and 2'b11.
- R6: While stall_i is high, xfer_valid_o is low and no transfer is consumed. The pending register index and address stay unchanged.
- R7: A start with an all-zero bitmap produces no transfer. done_o is high in the cycle after the start.
- R8: done_o is a single-cycle pulse in the cycle after the last transfer. wb_valid_o equals done_o when writeback was enabled at start and is low otherwise, and wb_addr_o carries the R5 value while wb_valid_o is high.
- R9: start_i is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture the operation inputs when idle |
| reg_list_i | input | 16 | Register selection bitmap |
| base_i | input | 32 | Base address |
| mode_i | input | 2 | Stepping mode: bit 1 = step down, bit 0 = step before |
| wb_en_i | input | 1 | Request base writeback |
| stall_i | input | 1 | Hold the current transfer |
| busy_o | output | 1 | Operation in progress |
| xfer_valid_o | output | 1 | Transfer issued this cycle |
| xfer_reg_o | output | 4 | Register index of the transfer |
| xfer_addr_o | output | 32 | Word address of the transfer |
| done_o | output | 1 | Operation finished |
| wb_valid_o | output | 1 | Writeback value valid |
| wb_addr_o | output | 32 | Updated base value |

## Verification
The bench builds the block with its defaults: 16 registers, 32-bit addresses and 4-byte words. With these values a full bitmap, the longest operation, takes sixteen cycles. The step-down arithmetic can also be driven from a small base so that it wraps below zero. Stalls are applied in a repeating pattern in the middle of operations, and a second start is injected while busy to confirm it is dropped. The empty bitmap is run with writeback enabled, so the unchanged base must appear at writeback.

// File: rtl/bts_pkg.sv
package bts_pkg;
  // bit 1: step down, bit 0: step before access
  typedef enum logic [1:0] {
    MODE_UP_AFTER   = 2'b00,
    MODE_UP_BEFORE  = 2'b01,
    MODE_DN_AFTER   = 2'b10,
    MODE_DN_BEFORE  = 2'b11
  } step_mode_e;
endpackage

// File: rtl/bts_popcount.sv
module bts_popcount #(
  parameter int W  = 16,
  parameter int CW = 5
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/bts_lowest.sv
module bts_lowest #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  mask_i,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  rest_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) if (mask_i[i]) idx_o = IW'(i);
  end
  // clear lowest set bit
  assign rest_o = mask_i & (mask_i - W'(1));
endmodule

// File: rtl/bts_addr_calc.sv
module bts_addr_calc
  import bts_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 5,
  parameter int BSH = 2
) (
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  step_mode_e    mode_i,
  output logic [AW-1:0] first_o,
  output logic [AW-1:0] wb_o
);
  localparam logic [AW-1:0] STEP = AW'(1) << BSH;
  logic [AW-1:0] span;

  assign span = AW'(cnt_i) << BSH;
  assign wb_o = mode_i[1] ? (base_i - span) : (base_i + span);

  always_comb begin
    unique case (mode_i)
      MODE_UP_AFTER:  first_o = base_i;
      MODE_UP_BEFORE: first_o = base_i + STEP;
      MODE_DN_AFTER:  first_o = base_i - span + STEP;
      default:        first_o = base_i - span;
    endcase
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import bts_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [NUM_REGS-1:0]         reg_list_i,
  input  logic [ADDR_W-1:0]           base_i,
  input  logic [1:0]                  mode_i,
  input  logic                        wb_en_i,
  input  logic                        stall_i,
  output logic                        busy_o,
  output logic                        xfer_valid_o,
  output logic [$clog2(NUM_REGS)-1:0] xfer_reg_o,
  output logic [ADDR_W-1:0]           xfer_addr_o,
  output logic                        done_o,
  output logic                        wb_valid_o,
  output logic [ADDR_W-1:0]           wb_addr_o
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int CNT_W = $clog2(NUM_REGS + 1);
  localparam int BSH   = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << BSH;

  logic                busy_q, done_q, wb_en_q;
  logic [NUM_REGS-1:0] mask_q, mask_rest;
  logic [ADDR_W-1:0]   addr_q, wb_q, first_addr, wb_calc;
  logic [CNT_W-1:0]    sel_cnt;
  logic                fire;

  bts_popcount #(.W(NUM_REGS), .CW(CNT_W)) u_cnt (
    .vec_i (reg_list_i),
    .cnt_o (sel_cnt)
  );

  bts_addr_calc #(.AW(ADDR_W), .CW(CNT_W), .BSH(BSH)) u_calc (
    .base_i  (base_i),
    .cnt_i   (sel_cnt),
    .mode_i  (step_mode_e'(mode_i)),
    .first_o (first_addr),
    .wb_o    (wb_calc)
  );

  bts_lowest #(.W(NUM_REGS), .IW(IDX_W)) u_low (
    .mask_i (mask_q),
    .idx_o  (xfer_reg_o),
    .rest_o (mask_rest)
  );

  assign fire = busy_q & ~stall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      wb_en_q <= 1'b0;
      mask_q  <= '0;
      addr_q  <= '0;
      wb_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start_i) begin
        mask_q  <= reg_list_i;
        addr_q  <= first_addr;
        wb_q    <= wb_calc;
        wb_en_q <= wb_en_i;
        busy_q  <= |reg_list_i;
        done_q  <= ~|reg_list_i;  // empty list completes at once
      end else if (fire) begin
        mask_q <= mask_rest;
        addr_q <= addr_q + STEP;
        if (mask_rest == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign xfer_valid_o = fire;
  assign xfer_addr_o  = addr_q;
  assign done_o       = done_q;
  assign wb_valid_o   = done_q & wb_en_q;
  assign wb_addr_o    = wb_q;
endmodule

// File: rtl/bts_checker.sv
module bts_checker #(
  parameter int NUM_REGS   = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        stall_i,
  input logic                        busy_o,
  input logic                        xfer_valid_o,
  input logic [$clog2(NUM_REGS)-1:0] xfer_reg_o,
  input logic [ADDR_W-1:0]           xfer_addr_o,
  input logic                        done_o,
  input logic                        wb_valid_o
);
  assert_valid_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> busy_o);

  assert_reg_ascend_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(xfer_valid_o) && xfer_valid_o) |-> (xfer_reg_o > $past(xfer_reg_o)));

  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(xfer_valid_o) && xfer_valid_o) |->
      (xfer_addr_o == $past(xfer_addr_o) + ADDR_W'(WORD_BYTES)));

  assert_stall_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !xfer_valid_o);

  assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && stall_i) |=> (busy_o && $stable(xfer_addr_o) && $stable(xfer_reg_o)));

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !xfer_valid_o));

  assert_wb_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> done_o);
endmodule

bind blk_xfer_seq bts_checker #(
  .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stall_i(stall_i), .busy_o(busy_o),
  .xfer_valid_o(xfer_valid_o), .xfer_reg_o(xfer_reg_o), .xfer_addr_o(xfer_addr_o),
  .done_o(done_o), .wb_valid_o(wb_valid_o)
);

// File: tb/blk_xfer_seq_tb_top.sv
module blk_xfer_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] reg_list_i = '0;
  logic [31:0] base_i = '0;
  logic [1:0]  mode_i = '0;
  logic        wb_en_i = 1'b0;
  logic        stall_i = 1'b0;
  logic        busy_o, xfer_valid_o, done_o, wb_valid_o;
  logic [3:0]  xfer_reg_o;
  logic [31:0] xfer_addr_o, wb_addr_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  blk_xfer_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .reg_list_i(reg_list_i),
    .base_i(base_i), .mode_i(mode_i), .wb_en_i(wb_en_i), .stall_i(stall_i),
    .busy_o(busy_o), .xfer_valid_o(xfer_valid_o), .xfer_reg_o(xfer_reg_o),
    .xfer_addr_o(xfer_addr_o), .done_o(done_o), .wb_valid_o(wb_valid_o),
    .wb_addr_o(wb_addr_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 50000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
      summary();
    end
  end

  // Reference: list of (reg,addr) pairs from the requirements, walked one per unstalled cycle.
  task automatic run_op(input logic [15:0] list, input logic [31:0] base,
                        input logic [1:0] mode, input bit wb, input bit stalls,
                        input bit inject);
    int regs[$];
    logic [31:0] first, wbv, span;
    int k = 0;
    int c = 0;
    for (int i = 0; i < 16; i++) if (list[i]) regs.push_back(i);
    span = 32'(regs.size()) * 32'd4;
    case (mode)
      2'b00: first = base;                 // R4
      2'b01: first = base + 32'd4;         // R4
      2'b10: first = base - span + 32'd4;  // R4
      default: first = base - span;        // R4
    endcase
    wbv = mode[1] ? base - span : base + span;  // R5
    @(negedge clk_i);
    start_i = 1'b1; reg_list_i = list; base_i = base; mode_i = mode;
    wb_en_i = wb; stall_i = 1'b0;
    while (k < regs.size()) begin
      @(negedge clk_i);
      start_i = 1'b0;
      stall_i = stalls && (c % 3 == 1);
      if (inject && c == 2) begin  // R9: must be ignored
        start_i = 1'b1; reg_list_i = 16'h0001; base_i = 32'hDEAD_0000;
        mode_i = 2'b00; wb_en_i = ~wb;
      end
      #1;
      chk(busy_o == 1'b1, "R2 busy", 32'(busy_o), 32'd1);
      chk(xfer_valid_o == !stall_i, "R6 valid", 32'(xfer_valid_o), 32'(!stall_i));
      if (!stall_i) begin
        chk(xfer_reg_o == 4'(regs[k]), "R2 reg", 32'(xfer_reg_o), 32'(regs[k]));
        chk(xfer_addr_o == first + 32'(k) * 32'd4, "R3 addr", xfer_addr_o,
            first + 32'(k) * 32'd4);
      end
      chk(done_o == 1'b0, "R8 early done", 32'(done_o), 32'd0);
      @(posedge clk_i);
      if (!stall_i) k++;
      c++;
    end
    @(negedge clk_i);
    start_i = 1'b0; stall_i = 1'b0;
    #1;
    chk(done_o == 1'b1, (regs.size() == 0) ? "R7 done" : "R8 done", 32'(done_o), 32'd1);
    chk(busy_o == 1'b0 && xfer_valid_o == 1'b0, "R7 idle",
        32'({busy_o, xfer_valid_o}), 32'd0);
    chk(wb_valid_o == wb, "R8 wb_valid", 32'(wb_valid_o), 32'(wb));
    if (wb) chk(wb_addr_o == wbv, "R5 wb_addr", wb_addr_o, wbv);
    @(negedge clk_i);
    #1;
    chk(done_o == 1'b0 && wb_valid_o == 1'b0, "R8 pulse",
        32'({done_o, wb_valid_o}), 32'd0);
  endtask

  initial begin
    #1;
    chk(busy_o == 0 && xfer_valid_o == 0 && done_o == 0 && wb_valid_o == 0,
        "R1 reset", 32'({busy_o, xfer_valid_o, done_o, wb_valid_o}), 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(busy_o == 0 && done_o == 0, "R1 after release", 32'({busy_o, done_o}), 32'd0);
    run_op(16'h00A5, 32'h0000_1000, 2'b00, 1'b1, 1'b0, 1'b0);
    run_op(16'h8001, 32'h0000_2000, 2'b01, 1'b0, 1'b1, 1'b0);
    run_op(16'h0F0F, 32'h0000_3000, 2'b10, 1'b1, 1'b1, 1'b1);
    run_op(16'hFFFF, 32'h0000_4000, 2'b11, 1'b1, 1'b0, 1'b0);
    run_op(16'h0000, 32'h0000_5000, 2'b11, 1'b1, 1'b0, 1'b0);
    run_op(16'h0007, 32'h0000_0004, 2'b11, 1'b1, 1'b1, 1'b0);
    run_op(16'h4200, 32'h0000_0008, 2'b10, 1'b0, 1'b0, 1'b1);
    summary();
  end
endmodule